// File: doc/BRIEF.md
# Domain Collision Winner Arbiter

At the end of each tick, every tile in the fabric reports four values: whether it fired, which of the 16 domains it belongs to, an 8-bit priority and a 16-bit mask of the domains it wants reset when it wins. This block resolves those reports into per-domain results. For each domain it records whether any tile fired and whether two or more fired, which is a collision. It also picks one winner per domain. From the winners it builds the automatic reset mask. After the bus has been read out, it turns that mask into a one-cycle per-tile clear strobe. Each winner is left out of the strobe, and so is every tile the caller marks as an ancestor to keep.

The tile reports arrive as flat vectors and must be held stable from the start pulse until the clear strobe has been issued. The arbiter visits one tile per clock in ascending index order and keeps a running best per domain. Because lower indices are visited first, a later tile displaces the current best only with a strictly higher priority. Ties are therefore resolved toward the lowest index.

The controller has four states. ST_IDLE waits for a start pulse. ST_SCAN visits tiles 0 to NUM_TILES-1. ST_LATCH registers the results. ST_DONE holds them with ready raised. The transitions are as follows. IDLE goes to SCAN on start. SCAN goes to LATCH after the last tile. LATCH goes to DONE unconditionally. DONE goes to IDLE on apply, which also issues the clear strobe. DONE goes back to SCAN on start without apply.

Top module: `domain_winner_arbiter`

## Requirements
- R1: There are exactly 16 domains. The winner ID of domain d is at win_id_o[d*IDW +: IDW], where IDW = clog2(NUM_TILES). Each tile's domain is at dom_i[4t +: 4], its priority at pri_i[8t +: 8] and its reset mask at rmask_i[16t +: 16]. Results stay stable in ST_DONE until start or apply.
- R2: A domain with no fired tile has win_valid_o, collide_o and its winner ID field all zero.
- R3: A domain with exactly one fired tile has that tile as winner, with win_valid_o set and collide_o clear.
- R4: A domain with two or more fired tiles sets collide_o. Its winner is the fired tile with the highest priority.
- R5: Among fired tiles of a domain that share the highest priority, the lowest tile index wins.
- R6: reset_mask_o is the OR of the reset masks of the winners of all domains that had a fire. Domains without a fire contribute nothing.
- R7: tile_clear_o is zero except for the single cycle after apply_i is sampled in ST_DONE. In that cycle, bit t is set when bit dom(t) of reset_mask_o is set. The block then returns to ST_IDLE with ready low.
- R8: A domain winner and any tile with keep_i set are never included in tile_clear_o.
- R9: status_o bit 0 is ready (in ST_DONE). Bit 1 is ovf_i as sampled in ST_LATCH. Bit 2 is the OR of all collide_o bits.
- R10: Priority, domain and mask of a tile whose fire bit is clear have no effect on any result.
- R11: After reset all outputs are zero and ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scan (ST_IDLE, or ST_DONE without apply) |
| fire_i | input | NUM_TILES | Per-tile fire bit |
| dom_i | input | NUM_TILES*4 | Per-tile domain number |
| pri_i | input | NUM_TILES*PRI_W | Per-tile priority |
| rmask_i | input | NUM_TILES*16 | Per-tile reset-on-fire domain mask |
| ovf_i | input | 1 | Bus overflow of this tick, captured into status |
| keep_i | input | NUM_TILES | Ancestor tiles exempt from reset |
| apply_i | input | 1 | Readout finished; issue the clear strobe |
| ready_o | output | 1 | Results valid (ST_DONE) |
| collide_o | output | 16 | Per-domain collision |
| win_valid_o | output | 16 | Per-domain winner present |
| win_id_o | output | 16*IDW | Per-domain winner tile index |
| reset_mask_o | output | 16 | Automatic reset domain mask |
| status_o | output | 3 | {collision-any, overflow, ready} |
| tile_clear_o | output | NUM_TILES | One-cycle per-tile clear strobe |

## Verification
The bench covers several corner cases, each aimed at a specific mistake.
- A whole domain of equal priorities: a design whose replace test uses "greater or equal" would pick the last tile instead of tile 0.
- A domain whose highest priority sits at the last index: a design that kept the first fired tile would miss it.
- Non-firing tiles given the top priority in a fired domain: a scan that ignored the fire bit would elect one of them.
- The apply step, with a winner and a kept ancestor inside a reset domain: exemptions that were dropped, or a strobe that lasted more than one cycle, would show up directly on tile_clear_o.

// File: rtl/dwa_pkg.sv
package dwa_pkg;
    localparam int NUM_DOM = 16;
    localparam int DOM_W   = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_LATCH = 2'd2,
        ST_DONE  = 2'd3
    } dwa_state_e;
endpackage

// File: rtl/dwa_domain_track.sv
module dwa_domain_track #(
    parameter int PRI_W = 8,
    parameter int IDW   = 4,
    parameter int MSK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             hit_i,
    input  logic [PRI_W-1:0] pri_i,
    input  logic [IDW-1:0]   idx_i,
    input  logic [MSK_W-1:0] mask_i,
    output logic             any_o,
    output logic             coll_o,
    output logic [IDW-1:0]   best_idx_o,
    output logic [MSK_W-1:0] best_mask_o
);
    logic [1:0]       cnt_q;
    logic [PRI_W-1:0] best_pri_q;
    logic [IDW-1:0]   best_idx_q;
    logic [MSK_W-1:0] best_mask_q;
    logic             take;

    // Lower indices arrive first, so only a strictly higher priority replaces.
    assign take = hit_i && ((cnt_q == 2'd0) || (pri_i > best_pri_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            best_pri_q  <= '0;
            best_idx_q  <= '0;
            best_mask_q <= '0;
        end else if (clr_i) begin
            cnt_q       <= '0;
            best_pri_q  <= '0;
            best_idx_q  <= '0;
            best_mask_q <= '0;
        end else begin
            if (hit_i && cnt_q != 2'd2) cnt_q <= cnt_q + 2'd1;
            if (take) begin
                best_pri_q  <= pri_i;
                best_idx_q  <= idx_i;
                best_mask_q <= mask_i;
            end
        end
    end

    assign any_o       = (cnt_q != 2'd0);
    assign coll_o      = (cnt_q == 2'd2);
    assign best_idx_o  = best_idx_q;
    assign best_mask_o = best_mask_q;

    AST_SAT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == 2'd2 && !clr_i) |=> cnt_q == 2'd2) else $error("count left saturation"); // R4
endmodule

// File: rtl/dwa_reset_apply.sv
module dwa_reset_apply #(
    parameter int NUM_TILES = 16,
    parameter int IDW       = 4
) (
    input  logic [NUM_TILES*dwa_pkg::DOM_W-1:0] dom_i,
    input  logic [NUM_TILES-1:0]                keep_i,
    input  logic [dwa_pkg::NUM_DOM-1:0]         win_valid_i,
    input  logic [dwa_pkg::NUM_DOM*IDW-1:0]     win_id_i,
    input  logic [dwa_pkg::NUM_DOM-1:0]         reset_mask_i,
    output logic [NUM_TILES-1:0]                clear_o
);
    localparam int DW = dwa_pkg::DOM_W;

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
        logic [DW-1:0] d;
        logic          is_win;
        assign d      = dom_i[t*DW +: DW];
        assign is_win = win_valid_i[d] && (win_id_i[d*IDW +: IDW] == IDW'(t));
        assign clear_o[t] = reset_mask_i[d] && !keep_i[t] && !is_win;
    end
endmodule

// File: rtl/domain_winner_arbiter.sv
module domain_winner_arbiter #(
    parameter int NUM_TILES = 16,
    parameter int PRI_W     = 8
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         start_i,
    input  logic [NUM_TILES-1:0]                         fire_i,
    input  logic [NUM_TILES*4-1:0]                       dom_i,
    input  logic [NUM_TILES*PRI_W-1:0]                   pri_i,
    input  logic [NUM_TILES*16-1:0]                      rmask_i,
    input  logic                                         ovf_i,
    input  logic [NUM_TILES-1:0]                         keep_i,
    input  logic                                         apply_i,
    output logic                                         ready_o,
    output logic [15:0]                                  collide_o,
    output logic [15:0]                                  win_valid_o,
    output logic [16*((NUM_TILES>1)?$clog2(NUM_TILES):1)-1:0] win_id_o,
    output logic [15:0]                                  reset_mask_o,
    output logic [2:0]                                   status_o,
    output logic [NUM_TILES-1:0]                         tile_clear_o
);
    import dwa_pkg::*;

    localparam int ND  = NUM_DOM;
    localparam int DW  = DOM_W;
    localparam int IDW = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1;
    localparam int MW  = NUM_DOM;

    dwa_state_e     state_q, state_d;
    logic [IDW-1:0] idx_q;
    logic           last_tile;
    logic           clr;

    logic [DW-1:0]    cur_dom;
    logic [PRI_W-1:0] cur_pri;
    logic [MW-1:0]    cur_mask;
    logic             cur_fire;

    logic [ND-1:0]     trk_any, trk_coll, hit;
    logic [ND*IDW-1:0] trk_idx;
    logic [MW-1:0]     trk_mask [ND];
    logic [MW-1:0]     or_mask;
    logic [1:0]        stat_q;
    logic [NUM_TILES-1:0] clear_c;

    assign cur_dom   = dom_i[idx_q*DW +: DW];
    assign cur_pri   = pri_i[idx_q*PRI_W +: PRI_W];
    assign cur_mask  = rmask_i[idx_q*MW +: MW];
    assign cur_fire  = fire_i[idx_q];
    assign last_tile = (idx_q == IDW'(NUM_TILES - 1));
    assign clr       = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE && !apply_i));

    for (genvar d = 0; d < ND; d++) begin : g_dom
        assign hit[d] = (state_q == ST_SCAN) && cur_fire && (cur_dom == DW'(d));
        dwa_domain_track #(.PRI_W(PRI_W), .IDW(IDW), .MSK_W(MW)) u_trk (
            .clk         (clk),
            .rst_n       (rst_n),
            .clr_i       (clr),
            .hit_i       (hit[d]),
            .pri_i       (cur_pri),
            .idx_i       (idx_q),
            .mask_i      (cur_mask),
            .any_o       (trk_any[d]),
            .coll_o      (trk_coll[d]),
            .best_idx_o  (trk_idx[d*IDW +: IDW]),
            .best_mask_o (trk_mask[d])
        );

        AST_COLL_HAS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
            collide_o[d] |-> win_valid_o[d]) else $error("collision without winner"); // R4
        AST_WINNER_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
            win_valid_o[d] |-> !tile_clear_o[win_id_o[d*IDW +: IDW]]) else $error("winner cleared"); // R8
    end

    always_comb begin
        or_mask = '0;
        for (int d = 0; d < ND; d++)
            if (trk_any[d]) or_mask = or_mask | trk_mask[d];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SCAN;
            ST_SCAN:  if (last_tile) state_d = ST_LATCH;
            ST_LATCH: state_d = ST_DONE;
            ST_DONE: begin
                if (apply_i)      state_d = ST_IDLE;
                else if (start_i) state_d = ST_SCAN;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (clr)                      idx_q <= '0;
            else if (state_q == ST_SCAN)  idx_q <= IDW'(idx_q + 1'b1);
        end
    end

    dwa_reset_apply #(.NUM_TILES(NUM_TILES), .IDW(IDW)) u_apply (
        .dom_i        (dom_i),
        .keep_i       (keep_i),
        .win_valid_i  (win_valid_o),
        .win_id_i     (win_id_o),
        .reset_mask_i (reset_mask_o),
        .clear_o      (clear_c)
    );

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            collide_o    <= '0;
            win_valid_o  <= '0;
            win_id_o     <= '0;
            reset_mask_o <= '0;
            stat_q       <= '0;
            tile_clear_o <= '0;
        end else begin
            if (state_q == ST_LATCH) begin
                collide_o    <= trk_coll;
                win_valid_o  <= trk_any;
                win_id_o     <= trk_idx;
                reset_mask_o <= or_mask;
                stat_q       <= {|trk_coll, ovf_i};
            end
            tile_clear_o <= (state_q == ST_DONE && apply_i) ? clear_c : '0;
        end
    end

    assign ready_o  = (state_q == ST_DONE);
    assign status_o = {stat_q, ready_o};

    AST_CLEAR_AFTER_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (|tile_clear_o) |-> ($past(apply_i) && state_q == ST_IDLE)) else $error("clear without apply"); // R7
    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|tile_clear_o) |=> (tile_clear_o == '0)) else $error("clear lasted"); // R7
    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !apply_i && !start_i) |=> ($stable(win_id_o) && $stable(reset_mask_o) && $stable(collide_o)))
        else $error("results moved in done"); // R1
    AST_COLL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (status_o[2] == (|collide_o))) else $error("collision-any mismatch"); // R9
endmodule

// File: tb/domain_winner_arbiter_tb.sv
module domain_winner_arbiter_tb;
    localparam int NT  = 16;
    localparam int IDW = 4;
    localparam int VW  = 16 + 64 + 128;

    // {fire, domains (nibble per tile), priorities (byte per tile)}
    localparam logic [VW-1:0] VEC [6] = '{
        {16'h0000, 64'hFEDCBA98_76543210, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF},
        {16'h0001, 64'h00000000_00000000, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFF01},
        {16'hFFFF, 64'h33333333_33333333, 128'h10101010_10101010_10101010_10101010},
        {16'hFFFF, 64'hFEDCBA98_76543210, 128'h0F0E0D0C_0B0A0908_07060504_03020100},
        {16'hA5A5, 64'h12121212_21212121, 128'h11223344_55667788_88776655_44332211},
        {16'h8001, 64'h55555555_55555555, 128'hFF000000_00000000_00000000_00000001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, ovf_i = 1'b0, apply_i = 1'b0;
    logic [NT-1:0]     fire_i = '0, keep_i = '0;
    logic [NT*4-1:0]   dom_i = '0;
    logic [NT*8-1:0]   pri_i = '0;
    logic [NT*16-1:0]  rmask_i = '0;
    logic ready_o;
    logic [15:0] collide_o, win_valid_o, reset_mask_o;
    logic [16*IDW-1:0] win_id_o;
    logic [2:0]  status_o;
    logic [NT-1:0] tile_clear_o;

    int checks = 0, fails = 0;
    logic [15:0] e_coll, e_val, e_rm;
    logic [16*IDW-1:0] e_id;

    always #2.5 clk = ~clk;

    domain_winner_arbiter #(.NUM_TILES(NT), .PRI_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fire_i(fire_i), .dom_i(dom_i),
        .pri_i(pri_i), .rmask_i(rmask_i), .ovf_i(ovf_i), .keep_i(keep_i), .apply_i(apply_i),
        .ready_o(ready_o), .collide_o(collide_o), .win_valid_o(win_valid_o), .win_id_o(win_id_o),
        .reset_mask_o(reset_mask_o), .status_o(status_o), .tile_clear_o(tile_clear_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Reference: descending scan with >= leaves the lowest index on ties.
    task automatic model();
        e_coll = '0; e_val = '0; e_rm = '0; e_id = '0;
        for (int d = 0; d < 16; d++) begin
            int cnt = 0;
            int best = -1;
            int bp = 0;
            for (int t = NT - 1; t >= 0; t--) begin
                if (fire_i[t] && dom_i[t*4 +: 4] == d[3:0]) begin
                    cnt++;
                    if (best < 0 || int'(pri_i[t*8 +: 8]) >= bp) begin
                        best = t;
                        bp = int'(pri_i[t*8 +: 8]);
                    end
                end
            end
            if (cnt > 0) begin
                e_val[d] = 1'b1;
                e_id[d*IDW +: IDW] = best[IDW-1:0];
                e_rm = e_rm | rmask_i[best*16 +: 16];
            end
            if (cnt > 1) e_coll[d] = 1'b1;
        end
    endtask

    task automatic run_scan();
        int n = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        while (!ready_o && n < 200) begin
            @(negedge clk); n++;
        end
        chk(ready_o, "R9 ready reached", 64'(ready_o), 64'd1);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!ready_o && collide_o == 0 && win_valid_o == 0 && win_id_o == 0 && reset_mask_o == 0
            && status_o == 0 && tile_clear_o == 0, "R11 reset state",
            {ready_o, status_o, tile_clear_o, reset_mask_o, win_valid_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 6; k++) begin
            {fire_i, dom_i, pri_i} = VEC[k];
            for (int t = 0; t < NT; t++) rmask_i[t*16 +: 16] = 16'h0001 << ((t * 7 + k) % 16);
            model();
            run_scan();
            // R2 R3 R4 R5 R10: per-domain results; R1: packed ID fields
            chk(collide_o == e_coll, "R4 collide mask", 64'(collide_o), 64'(e_coll));
            chk(win_valid_o == e_val, "R2 R3 winner valid", 64'(win_valid_o), 64'(e_val));
            chk(win_id_o == e_id, "R1 R5 R10 winner ids", 64'(win_id_o), 64'(e_id));
            chk(reset_mask_o == e_rm, "R6 reset mask", 64'(reset_mask_o), 64'(e_rm));
            chk(status_o == {|e_coll, 1'b0, 1'b1}, "R9 status", 64'(status_o), 64'({|e_coll, 2'b01}));
            chk(tile_clear_o == 0, "R7 no clear before apply", 64'(tile_clear_o), 64'd0);
        end

        // R5 explicit: all-equal priorities in domain 3 -> tile 0
        {fire_i, dom_i, pri_i} = VEC[2];
        run_scan();
        chk(win_id_o[3*IDW +: IDW] == 0 && collide_o[3], "R5 tie lowest index",
            64'(win_id_o[3*IDW +: IDW]), 64'd0);
        // R10: non-firing tiles with top priority in domain 0 do not win
        {fire_i, dom_i, pri_i} = VEC[1];
        ovf_i = 1'b1;
        run_scan();
        ovf_i = 1'b0;
        chk(win_id_o[0 +: IDW] == 0 && collide_o == 0, "R10 non-fire ignored",
            64'(win_id_o[0 +: IDW]), 64'd0);
        chk(status_o == 3'b011, "R9 overflow captured", 64'(status_o), 64'h3);

        // R7 R8: apply with winner and kept ancestor in the reset domain
        fire_i = 16'h0024;
        dom_i  = 64'h44444444_33333333;
        pri_i  = '0;
        for (int t = 0; t < NT; t++) rmask_i[t*16 +: 16] = 16'h0008;
        keep_i = 16'h0040;
        run_scan();
        chk(win_id_o[3*IDW +: IDW] == 2 && reset_mask_o == 16'h0008, "R6 apply setup",
            {win_id_o[3*IDW +: IDW], reset_mask_o}, {4'd2, 16'h0008});
        apply_i = 1'b1;
        @(negedge clk);
        apply_i = 1'b0;
        chk(tile_clear_o == 16'h00BB, "R8 clear excludes winner and keep", 64'(tile_clear_o), 64'h00BB);
        chk(!ready_o, "R7 back to idle", 64'(ready_o), 64'd0);
        @(negedge clk);
        chk(tile_clear_o == 0, "R7 clear one cycle", 64'(tile_clear_o), 64'd0);
        keep_i = '0;

        summary();
    end
endmodule